// File: doc/BRIEF.md
# Multi-Channel Edge-Positioned PWM Generator

This block drives sixteen pulse-width outputs from one shared timebase. An 8-bit prescaler divides the clock. Each time it wraps, an 8-bit step counter advances. The step counter runs from 0 to the programmed period value and then returns to 0. A channel's waveform is not given as a duty value. It is given by two step positions: the step at which the output is driven high and the step at which it is driven low. Equal positions make the output flip once per period. A position past the period value never matches, which holds the output at one level.

Software reaches the block through a small word-addressed register bus. Writes are single-cycle and reads are combinational. The `SHADOW_MASK` parameter selects which channels stage their edge writes. On a staged channel, written values wait in a holding copy. They move into effect only at the period boundary that follows a write to the sync command word. Reads always return the values currently in use. Channels without staging apply a write on the next clock edge, even in the middle of a period.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset, every readable register is 0, every channel is disabled and `pwm_o` is all zeros.
- R2: Register word addresses (byte address divided by 4) are as follows. Prescale is word 0. Period is word 1. Enables for channels 0-7 are word 2, bit i = channel i. Enables for channels 8-15 are word 3, bit i-8 = channel i. Channel i's high-edge step is word 4+2i and its low-edge step is word 5+2i. A write takes effect when `bus_req_i` and `bus_we_i` are both high at a clock edge. `bus_rdata_o` shows the addressed register combinationally.
- R3: One output period lasts (prescale+1)*(period+1) clocks, and all channels share it.
- R4: When rise < fall <= period, an enabled channel is high for (fall-rise)*(prescale+1) clocks of each period.
- R5: When fall < rise <= period, the high interval wraps through step 0, giving (period+1-rise+fall)*(prescale+1) high clocks per period.
- R6: When rise equals fall, the output toggles once per period, giving a 50% waveform with twice the programmed period.
- R7: An edge value greater than the period value never fires. Rise 0 with fall above the period holds the output high. Rise above the period with fall 0 holds it low.
- R8: With period 255, rise 0 and fall 255, the output is low for one step of each period, so 100% duty cannot be reached.
- R9: A channel whose enable bit is clear drives 0.
- R10: On a channel without staging, an edge write is visible on readback and in effect from the next clock.
- R11: On a staged channel, an edge write is held back. Readback keeps returning the active value until the first period boundary after a write to the sync word, which is word 57 (byte 0xE4). At that boundary the held values take effect.
- R12: The sync word always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed word |
| pwm_o | output | 16 | Channel outputs |

## Verification
The bench counts high cycles over exact period windows. With this method, a design that places an edge one step early or late, or that mishandles the wrapped interval, shows up as a wrong count. Equal edges are checked over two periods, because a design that re-toggles on every prescale clock, or that never toggles, loses the 50% result. Edges beyond the period are checked for both stuck levels, and a full-range period is checked for the missing high step. Staged channels are probed right after the sync write and again after the boundary. A design that commits on write, or never commits, returns the wrong readback.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int unsigned REG_W        = 8;
  localparam int unsigned WA_PRESCALE  = 0;
  localparam int unsigned WA_PERIOD    = 1;
  localparam int unsigned WA_EN_BASE   = 2;
  localparam int unsigned WA_EDGE_BASE = 4;
  localparam int unsigned WA_SYNC      = 57;  // byte 0xE4
endpackage

// File: rtl/pwm_edge_timebase.sv
module pwm_edge_timebase #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] prescale_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] step_o,
  output logic         step_start_o,
  output logic         boundary_o
);
  logic [W-1:0] pre_q, step_q;
  logic         tick;

  assign tick         = (pre_q >= prescale_i);
  assign boundary_o   = tick && (step_q >= period_i);
  assign step_start_o = (pre_q == '0);
  assign step_o       = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + W'(1);
      if (tick) step_q <= (step_q >= period_i) ? '0 : step_q + W'(1);
    end
  end
endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel #(
  parameter int unsigned W      = 8,
  parameter bit          SHADOW = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_rise_i,
  input  logic         wr_fall_i,
  input  logic [W-1:0] wdata_i,
  input  logic         commit_i,
  input  logic         en_i,
  input  logic [W-1:0] step_i,
  input  logic         step_start_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic         pwm_o
);
  logic [W-1:0] rise_q, fall_q;
  logic         out_q, hit_r, hit_f;

  if (SHADOW) begin : g_staged
    logic [W-1:0] rise_stg_q, fall_stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_stg_q <= '0;
        fall_stg_q <= '0;
        rise_q     <= '0;
        fall_q     <= '0;
      end else begin
        if (wr_rise_i) rise_stg_q <= wdata_i;
        if (wr_fall_i) fall_stg_q <= wdata_i;
        if (commit_i) begin
          rise_q <= rise_stg_q;
          fall_q <= fall_stg_q;
        end
      end
    end
  end else begin : g_direct
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_q <= '0;
        fall_q <= '0;
      end else begin
        if (wr_rise_i) rise_q <= wdata_i;
        if (wr_fall_i) fall_q <= wdata_i;
      end
    end
  end

  assign hit_r = (step_i == rise_q);
  assign hit_f = (step_i == fall_q);

  // edges are evaluated once per step, on its first clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                out_q <= 1'b0;
    else if (!en_i)             out_q <= 1'b0;
    else if (step_start_i) begin
      if (hit_r && hit_f)       out_q <= ~out_q;
      else if (hit_r)           out_q <= 1'b1;
      else if (hit_f)           out_q <= 1'b0;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign pwm_o  = out_q;
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_edge_pkg::*;
#(
  parameter int unsigned          N_CH        = 16,
  parameter int unsigned          ADDR_W      = 6,
  parameter logic [N_CH-1:0]      SHADOW_MASK = 16'hFF00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  localparam int unsigned N_BANKS = (N_CH + REG_W - 1) / REG_W;

  logic [REG_W-1:0]         presc_q, per_q, step;
  logic [N_BANKS*REG_W-1:0] en_q;
  logic                     pend_q, wr, sync_wr, step_start, boundary, commit;
  logic [N_CH-1:0]          wr_rise, wr_fall;
  logic [N_CH-1:0][REG_W-1:0] rise_act, fall_act;

  assign wr      = bus_req_i && bus_we_i;
  assign sync_wr = wr && (bus_addr_i == ADDR_W'(WA_SYNC));
  assign commit  = boundary && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      per_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr && bus_addr_i == ADDR_W'(WA_PRESCALE)) presc_q <= bus_wdata_i;
      if (wr && bus_addr_i == ADDR_W'(WA_PERIOD))   per_q   <= bus_wdata_i;
      if (sync_wr)       pend_q <= 1'b1;
      else if (boundary) pend_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < N_BANKS; k++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[k*REG_W +: REG_W] <= '0;
      else if (wr && bus_addr_i == ADDR_W'(WA_EN_BASE + k))
        en_q[k*REG_W +: REG_W] <= bus_wdata_i;
    end
  end

  pwm_edge_timebase #(.W(REG_W)) i_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prescale_i  (presc_q),
    .period_i    (per_q),
    .step_o      (step),
    .step_start_o(step_start),
    .boundary_o  (boundary)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign wr_rise[c] = wr && (bus_addr_i == ADDR_W'(WA_EDGE_BASE + 2*c));
    assign wr_fall[c] = wr && (bus_addr_i == ADDR_W'(WA_EDGE_BASE + 2*c + 1));

    pwm_edge_channel #(.W(REG_W), .SHADOW(SHADOW_MASK[c])) i_channel (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_rise_i   (wr_rise[c]),
      .wr_fall_i   (wr_fall[c]),
      .wdata_i     (bus_wdata_i),
      .commit_i    (commit),
      .en_i        (en_q[c]),
      .step_i      (step),
      .step_start_i(step_start),
      .rise_o      (rise_act[c]),
      .fall_o      (fall_act[c]),
      .pwm_o       (pwm_o[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(WA_PRESCALE)) bus_rdata_o = presc_q;
    if (bus_addr_i == ADDR_W'(WA_PERIOD))   bus_rdata_o = per_q;
    for (int k = 0; k < N_BANKS; k++)
      if (bus_addr_i == ADDR_W'(WA_EN_BASE + k)) bus_rdata_o = en_q[k*REG_W +: REG_W];
    for (int c = 0; c < N_CH; c++) begin
      if (bus_addr_i == ADDR_W'(WA_EDGE_BASE + 2*c))     bus_rdata_o = rise_act[c];
      if (bus_addr_i == ADDR_W'(WA_EDGE_BASE + 2*c + 1)) bus_rdata_o = fall_act[c];
    end
  end
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk
  import pwm_edge_pkg::*;
#(
  parameter int unsigned     N_CH        = 16,
  parameter int unsigned     ADDR_W      = 6,
  parameter int unsigned     N_BANKS     = 2,
  parameter logic [N_CH-1:0] SHADOW_MASK = '0
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          bus_addr_i,
  input logic [REG_W-1:0]           bus_wdata_i,
  input logic [REG_W-1:0]           bus_rdata_o,
  input logic [N_CH-1:0]            pwm_o,
  input logic [N_BANKS*REG_W-1:0]   en_q,
  input logic [REG_W-1:0]           step,
  input logic                       boundary,
  input logic                       commit,
  input logic [N_CH-1:0]            wr_rise,
  input logic [N_CH-1:0][REG_W-1:0] rise_act
);
  a_r9_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o & ~$past(en_q[N_CH-1:0])) == '0);

  a_r12_sync_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(WA_SYNC)) |-> (bus_rdata_o == '0));

  a_r3_boundary_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary |=> (step == '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    if (SHADOW_MASK[c]) begin : g_st
      a_r11_held_until_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(commit) |-> $stable(rise_act[c]));
    end else begin : g_dir
      a_r10_write_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_rise[c]) |-> (rise_act[c] == $past(bus_wdata_i)));
    end
  end
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(
  .N_CH(N_CH), .ADDR_W(ADDR_W), .N_BANKS(N_BANKS), .SHADOW_MASK(SHADOW_MASK)
) i_chk (.*);

// File: tb/test_pwm_edge_gen.sv
module test_pwm_edge_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [15:0] pwm_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_edge_gen i_pwm_edge_gen (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = 6'(a); bus_wdata_i = 8'(d);
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk_i);
    bus_addr_i = 6'(a);
    #1 d = int'(bus_rdata_o);
  endtask

  task automatic count_high(int ch, int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk_i);
      cnt += int'(pwm_o[ch]);
    end
  endtask

  task automatic wait_rise(int ch);
    bit prev = pwm_o[ch];
    forever begin
      @(negedge clk_i);
      if (pwm_o[ch] && !prev) break;
      prev = pwm_o[ch];
    end
  endtask

  task automatic t_reset();
    int d;
    check("R1 pwm_o", int'(pwm_o), 0);
    for (int a = 0; a < 36; a++) begin
      rd(a, d);
      check("R1 register", d, 0);
    end
  endtask

  task automatic t_waveforms();
    int d, c;
    wr(0, 1); wr(1, 9);               // 20-clock period
    wr(4, 2);  wr(5, 6);              // ch0
    wr(14, 7); wr(15, 2);             // ch5 wrapped
    wr(6, 4);  wr(7, 4);              // ch1 equal
    wr(8, 0);  wr(9, 10);             // ch2 stuck high
    wr(10, 10); wr(11, 0);            // ch3 stuck low
    wr(12, 0); wr(13, 5);             // ch4 left disabled
    wr(2, 8'h2F);
    rd(0, d);  check("R2 prescale", d, 1);
    rd(1, d);  check("R2 period", d, 9);
    rd(2, d);  check("R2 enable lo", d, 8'h2F);
    rd(14, d); check("R2 ch5 rise", d, 7);
    rd(15, d); check("R2 ch5 fall", d, 2);
    repeat (60) @(negedge clk_i);
    count_high(0, 20, c); check("R4 ch0 high", c, 8);
    count_high(5, 20, c); check("R5 ch5 wrap high", c, 10);
    count_high(1, 40, c); check("R6 ch1 equal edges", c, 20);
    count_high(2, 20, c); check("R7 ch2 stuck high", c, 20);
    count_high(3, 20, c); check("R7 ch3 stuck low", c, 0);
    count_high(4, 20, c); check("R9 ch4 disabled", c, 0);
  endtask

  task automatic t_period();
    int n;
    wait_rise(0);
    n = 0;
    begin : meas1
      bit prev = 1'b1;
      forever begin
        @(negedge clk_i); n++;
        if (pwm_o[0] && !prev) break;
        prev = pwm_o[0];
      end
    end
    check("R3 period 2x10", n, 20);
    wr(0, 2); wr(1, 4); wr(4, 1); wr(5, 3);
    repeat (40) @(negedge clk_i);
    wait_rise(0);
    n = 0;
    begin : meas2
      bit prev = 1'b1;
      forever begin
        @(negedge clk_i); n++;
        if (pwm_o[0] && !prev) break;
        prev = pwm_o[0];
      end
    end
    check("R3 period 3x5", n, 15);
  endtask

  task automatic t_full_range();
    int c;
    wr(0, 0); wr(1, 255); wr(4, 0); wr(5, 255);
    repeat (520) @(negedge clk_i);
    count_high(0, 256, c); check("R8 full range no 100%", c, 255);
  endtask

  task automatic t_direct();
    int d;
    wr(16, 33);
    rd(16, d); check("R10 ch6 rise immediate", d, 33);
  endtask

  task automatic t_shadow();
    int d, c;
    wr(0, 1); wr(1, 9); wr(4, 2); wr(5, 6);
    wr(20, 1); wr(21, 5);
    rd(20, d); check("R11 staged rise hidden", d, 0);
    repeat (40) @(negedge clk_i);
    rd(21, d); check("R11 no commit without sync", d, 0);
    wait_rise(0);
    wr(57, 1);
    rd(20, d); check("R11 held before boundary", d, 0);
    repeat (30) @(negedge clk_i);
    rd(20, d); check("R11 committed rise", d, 1);
    rd(21, d); check("R11 committed fall", d, 5);
    wr(3, 1);
    rd(3, d);  check("R2 enable hi", d, 1);
    repeat (40) @(negedge clk_i);
    count_high(8, 20, c); check("R11 ch8 active waveform", c, 8);
    rd(57, d); check("R12 sync reads zero", d, 0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_waveforms();
    t_period();
    t_full_range();
    t_direct();
    t_shadow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule